// File: doc/BRIEF.md
# Halfword Dot-Product Accumulate Unit

This block keeps a small bank of 64-bit signed accumulators and, on each start strobe, folds a two-lane dot product into one of them. Each 32-bit operand carries two signed 16-bit lanes. The two lane products are added to or subtracted from the selected accumulator. The lanes can be paired straight or crossed.

A fractional mode treats the lanes as Q15 values. In that mode each product is doubled, and the single product that cannot be represented (minus one times minus one) is pinned to the largest positive 32-bit value. An optional clamp limits the updated accumulator to the signed 32-bit range. Either event sets a sticky overflow bit that belongs to the accumulator concerned.

The accumulators are read through a combinational read port that returns the high and low words of the accumulator chosen by a read index.

Top module: `hdp_mac_unit`

## Requirements
- R1: With `cross_en`=0 and `op_kind`=0, the low lane of `opa` multiplies the low lane of `opb`, and the high lane of `opa` multiplies the high lane of `opb`. Lanes are signed 16-bit: the low lane is bits 15:0 and the high lane is bits 31:16. Both products are added to the selected accumulator.
- R2: With `op_kind`=1, both lane products are subtracted from the selected accumulator.
- R3: With `cross_en`=1, the low lane of `opa` multiplies the high lane of `opb`, and the high lane of `opa` multiplies the low lane of `opb`.
- R4: With `op_kind`=2, the low-lane product is subtracted and the high-lane product is added. The code `op_kind`=3 behaves exactly as `op_kind`=0.
- R5: With `frac_en`=1, each lane product is doubled before it is accumulated.
- R6: With `frac_en`=1, a lane whose two factors are both 0x8000 contributes 0x7FFFFFFF and sets the overflow flag of the selected accumulator.
- R7: With `sat_en`=1, an updated value above 0x7FFFFFFF is stored as 0x7FFFFFFF, and one below -0x80000000 is stored as -0x80000000. Either clamp sets the overflow flag of the selected accumulator.
- R8: An accumulator is a signed 64-bit value whose bits 63:32 are the high word and whose bits 31:0 are the low word. Arithmetic without the clamp wraps modulo 2^64. `rd_hi` and `rd_lo` show the accumulator addressed by `rd_idx` with no added latency.
- R9: `done` is high for exactly the cycle after a cycle in which `start` was sampled high. The accumulator update takes effect on that same clock edge.
- R10: `ovf_flags` bit i belongs to accumulator i. A set bit stays set until reset. An operation can set only the bit of the accumulator that `acc_sel` selects.
- R11: A synchronous reset clears all accumulators, all overflow flags and `done`.
- R12: The accumulators not selected by `acc_sel`, and all accumulators in cycles without `start`, keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin one dot-product operation |
| acc_sel | input | 2 | Accumulator written by the operation |
| opa | input | 32 | First operand, two signed 16-bit lanes |
| opb | input | 32 | Second operand, two signed 16-bit lanes |
| cross_en | input | 1 | Crossed lane pairing |
| op_kind | input | 2 | 0 add, 1 subtract, 2 subtract low and add high, 3 add |
| frac_en | input | 1 | Q15 fractional product mode |
| sat_en | input | 1 | Clamp the result to the signed 32-bit range |
| rd_idx | input | 2 | Accumulator shown on the read port |
| done | output | 1 | Pulse one cycle after start |
| rd_hi | output | 32 | High word of the addressed accumulator |
| rd_lo | output | 32 | Low word of the addressed accumulator |
| ovf_flags | output | 4 | Sticky per-accumulator overflow bits |

## Verification
The checker assumes that `start` is low while reset is held. Its stability checks also assume that `rd_idx` changes only between samples, with the bench keeping the read index steady across the clock edges it observes.

The bench drives every input at the falling edge. It lowers `start` in the cycle after each operation, so `done` is never stretched by back-to-back strobes.

Random operands are mixed with forced 0x8000 lanes, so the fractional corner case occurs often. Random clamp settings run against accumulators that have been allowed to grow past 32 bits, so both clamp directions are reached.

// File: rtl/hdp_pkg.sv
package hdp_pkg;
  typedef enum logic [1:0] {
    OPK_ADD = 2'd0,
    OPK_SUB = 2'd1,
    OPK_MIX = 2'd2,
    OPK_RSV = 2'd3
  } op_kind_e;
endpackage

// File: rtl/hdp_lane_mult.sv
module hdp_lane_mult #(
  parameter int LANE_W = 16
) (
  input  logic signed [LANE_W-1:0]   x,
  input  logic signed [LANE_W-1:0]   y,
  input  logic                       frac,
  output logic signed [2*LANE_W-1:0] prod,
  output logic                       corner
);
  localparam int PW = 2 * LANE_W;
  localparam logic [LANE_W-1:0] LANE_MIN = {1'b1, {(LANE_W-1){1'b0}}};
  localparam logic [PW-1:0]     PROD_MAX = {1'b0, {(PW-1){1'b1}}};

  logic signed [PW-1:0] raw;

  always_comb begin
    raw    = PW'(x) * PW'(y);
    corner = frac && (x == LANE_MIN) && (y == LANE_MIN);
    if (corner)    prod = PROD_MAX;
    else if (frac) prod = raw <<< 1;
    else           prod = raw;
  end
endmodule

// File: rtl/hdp_acc_sum.sv
module hdp_acc_sum
  import hdp_pkg::*;
#(
  parameter int ACC_W  = 64,
  parameter int PROD_W = 32,
  parameter int WORD_W = 32
) (
  input  logic signed [ACC_W-1:0]  acc_in,
  input  logic signed [PROD_W-1:0] p_lo,
  input  logic signed [PROD_W-1:0] p_hi,
  input  logic [1:0]               op_kind,
  input  logic                     sat_en,
  output logic signed [ACC_W-1:0]  acc_out,
  output logic                     clamp
);
  localparam int EXT_W = ACC_W - PROD_W;
  localparam logic signed [ACC_W-1:0] SAT_MAX = {{(ACC_W-WORD_W+1){1'b0}}, {(WORD_W-1){1'b1}}};
  localparam logic signed [ACC_W-1:0] SAT_MIN = {{(ACC_W-WORD_W+1){1'b1}}, {(WORD_W-1){1'b0}}};

  op_kind_e kind;
  logic neg_lo, neg_hi;
  logic signed [ACC_W-1:0] e_lo, e_hi, t_lo, t_hi, sum;

  always_comb begin
    kind   = op_kind_e'(op_kind);
    neg_lo = (kind == OPK_SUB) || (kind == OPK_MIX);
    neg_hi = (kind == OPK_SUB);
    e_lo   = {{EXT_W{p_lo[PROD_W-1]}}, p_lo};
    e_hi   = {{EXT_W{p_hi[PROD_W-1]}}, p_hi};
    t_lo   = neg_lo ? -e_lo : e_lo;
    t_hi   = neg_hi ? -e_hi : e_hi;
    sum    = acc_in + t_lo + t_hi;
    clamp  = 1'b0;
    acc_out = sum;
    if (sat_en && (sum > SAT_MAX)) begin
      acc_out = SAT_MAX;
      clamp   = 1'b1;
    end else if (sat_en && (sum < SAT_MIN)) begin
      acc_out = SAT_MIN;
      clamp   = 1'b1;
    end
  end
endmodule

// File: rtl/hdp_mac_unit.sv
module hdp_mac_unit #(
  parameter int LANE_W = 16,
  parameter int ACC_N  = 4
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [$clog2(ACC_N)-1:0]     acc_sel,
  input  logic [2*LANE_W-1:0]          opa,
  input  logic [2*LANE_W-1:0]          opb,
  input  logic                         cross_en,
  input  logic [1:0]                   op_kind,
  input  logic                         frac_en,
  input  logic                         sat_en,
  input  logic [$clog2(ACC_N)-1:0]     rd_idx,
  output logic                         done,
  output logic [2*LANE_W-1:0]          rd_hi,
  output logic [2*LANE_W-1:0]          rd_lo,
  output logic [ACC_N-1:0]             ovf_flags
);
  localparam int WORD_W = 2 * LANE_W;
  localparam int ACC_W  = 2 * WORD_W;
  localparam int PROD_W = 2 * LANE_W;
  localparam int IDX_W  = $clog2(ACC_N);
  localparam int LANES  = 2;

  logic [WORD_W-1:0] acc_hi_q [ACC_N];
  logic [WORD_W-1:0] acc_lo_q [ACC_N];

  logic signed [PROD_W-1:0] lane_prod [LANES];
  logic [LANES-1:0]         lane_corner;
  logic signed [ACC_W-1:0]  acc_cur, acc_nxt;
  logic                     sum_clamp;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] fx, fy;
    assign fx = opa[g*LANE_W +: LANE_W];
    assign fy = cross_en ? opb[(LANES-1-g)*LANE_W +: LANE_W]
                         : opb[g*LANE_W +: LANE_W];
    hdp_lane_mult #(.LANE_W(LANE_W)) u_mult (
      .x      (fx),
      .y      (fy),
      .frac   (frac_en),
      .prod   (lane_prod[g]),
      .corner (lane_corner[g])
    );
  end

  assign acc_cur = {acc_hi_q[acc_sel], acc_lo_q[acc_sel]};

  hdp_acc_sum #(.ACC_W(ACC_W), .PROD_W(PROD_W), .WORD_W(WORD_W)) u_sum (
    .acc_in  (acc_cur),
    .p_lo    (lane_prod[0]),
    .p_hi    (lane_prod[1]),
    .op_kind (op_kind),
    .sat_en  (sat_en),
    .acc_out (acc_nxt),
    .clamp   (sum_clamp)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ACC_N; i++) begin
        acc_hi_q[i] <= '0;
        acc_lo_q[i] <= '0;
      end
      ovf_flags <= '0;
      done      <= 1'b0;
    end else begin
      done <= start;
      if (start) begin
        acc_hi_q[acc_sel]  <= acc_nxt[ACC_W-1:WORD_W];
        acc_lo_q[acc_sel]  <= acc_nxt[WORD_W-1:0];
        ovf_flags[acc_sel] <= ovf_flags[acc_sel] | (|lane_corner) | sum_clamp;
      end
    end
  end

  assign rd_hi = acc_hi_q[rd_idx];
  assign rd_lo = acc_lo_q[rd_idx];

  logic [IDX_W-1:0] unused_idx_w;
  assign unused_idx_w = '0;
endmodule

// File: rtl/hdp_mac_chk.sv
module hdp_mac_chk #(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 2,
  parameter int ACC_N  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic              sat_en,
  input logic [IDX_W-1:0]  acc_sel,
  input logic [IDX_W-1:0]  rd_idx,
  input logic              done,
  input logic [WORD_W-1:0] rd_hi,
  input logic [WORD_W-1:0] rd_lo,
  input logic [ACC_N-1:0]  ovf_flags
);
  assert_done_after_start_R9: assert property (@(posedge clk) disable iff (rst)
    start |=> done);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !start |=> !done);

  assert_flags_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((ovf_flags & $past(ovf_flags)) == $past(ovf_flags)));

  assert_flag_single_R10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> $onehot0(ovf_flags & ~$past(ovf_flags)));

  assert_flags_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start)) |-> $stable(ovf_flags));

  assert_acc_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(start) && $stable(rd_idx)) |-> ($stable(rd_hi) && $stable(rd_lo)));

  assert_clamp_range_R7: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(start && sat_en) && rd_idx == $past(acc_sel))
      |-> (rd_hi == {WORD_W{rd_lo[WORD_W-1]}}));
endmodule

bind hdp_mac_unit hdp_mac_chk #(.WORD_W(WORD_W), .IDX_W(IDX_W), .ACC_N(ACC_N)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .start     (start),
  .sat_en    (sat_en),
  .acc_sel   (acc_sel),
  .rd_idx    (rd_idx),
  .done      (done),
  .rd_hi     (rd_hi),
  .rd_lo     (rd_lo),
  .ovf_flags (ovf_flags)
);

// File: tb/hdp_mac_unit_test.sv
module hdp_mac_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  acc_sel = '0;
  logic [31:0] opa = '0, opb = '0;
  logic        cross_en = 1'b0;
  logic [1:0]  op_kind = '0;
  logic        frac_en = 1'b0, sat_en = 1'b0;
  logic [1:0]  rd_idx = '0;
  logic        done;
  logic [31:0] rd_hi, rd_lo;
  logic [3:0]  ovf_flags;

  int n_checks = 0;
  int n_fail = 0;

  longint m_acc [4];
  logic [3:0] m_flag;

  always #10 clk = ~clk;

  hdp_mac_unit uut (
    .clk(clk), .rst(rst), .start(start), .acc_sel(acc_sel),
    .opa(opa), .opb(opb), .cross_en(cross_en), .op_kind(op_kind),
    .frac_en(frac_en), .sat_en(sat_en), .rd_idx(rd_idx),
    .done(done), .rd_hi(rd_hi), .rd_lo(rd_lo), .ovf_flags(ovf_flags)
  );

  task automatic check64(string tag, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic longint lane_prod(logic [15:0] a, logic [15:0] b, bit frac, ref bit corner);
    longint x = longint'(signed'(a));
    longint y = longint'(signed'(b));
    corner = 1'b0;
    if (frac && a == 16'h8000 && b == 16'h8000) begin
      corner = 1'b1;
      return 64'sh7FFFFFFF;
    end
    return frac ? (x * y * 2) : (x * y);
  endfunction

  task automatic model_op(int idx, logic [31:0] a, logic [31:0] b, bit cr, logic [1:0] ok, bit fr, bit sa);
    bit c0, c1;
    longint p0, p1, r;
    p0 = lane_prod(a[15:0], cr ? b[31:16] : b[15:0], fr, c0);
    p1 = lane_prod(a[31:16], cr ? b[15:0] : b[31:16], fr, c1);
    case (ok)
      2'd1:    r = m_acc[idx] - p0 - p1;
      2'd2:    r = m_acc[idx] - p0 + p1;
      default: r = m_acc[idx] + p0 + p1;
    endcase
    if (c0 || c1) m_flag[idx] = 1'b1;
    if (sa && r > 64'sd2147483647) begin
      r = 64'sd2147483647; m_flag[idx] = 1'b1;
    end else if (sa && r < -64'sd2147483648) begin
      r = -64'sd2147483648; m_flag[idx] = 1'b1;
    end
    m_acc[idx] = r;
  endtask

  task automatic check_all(string tag);
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #1;
      check64(tag, {rd_hi, rd_lo}, m_acc[i]);
    end
    check64({tag, "/R10 flags"}, 64'(ovf_flags), 64'(m_flag));
  endtask

  task automatic run_op(string tag, int idx, logic [31:0] a, logic [31:0] b, bit cr,
                        logic [1:0] ok, bit fr, bit sa);
    @(negedge clk);
    acc_sel = 2'(idx); opa = a; opb = b; cross_en = cr; op_kind = ok;
    frac_en = fr; sat_en = sa; start = 1'b1;
    model_op(idx, a, b, cr, ok, fr, sa);
    @(negedge clk);
    start = 1'b0;
    check64({tag, "/R9 done"}, 64'(done), 64'd1);
    check_all(tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 4; i++) m_acc[i] = 0;
    m_flag = '0;
    check64("R11 done after reset", 64'(done), 64'd0);
    check_all("R11 reset state");
  endtask

  initial begin
    #(20 * 150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    do_reset();
    run_op("R1 straight add", 0, {16'd3, 16'd5}, {16'd7, 16'hFFFE}, 0, 2'd0, 0, 0);
    run_op("R2 straight sub", 1, {16'd100, 16'd2}, {16'd4, 16'd9}, 0, 2'd1, 0, 0);
    run_op("R3 crossed add", 2, {16'd3, 16'd5}, {16'd7, 16'd11}, 1, 2'd0, 0, 0);
    run_op("R4 mixed", 3, {16'd10, 16'd6}, {16'd2, 16'd1}, 0, 2'd2, 0, 0);
    run_op("R4 code3 as add", 3, {16'hFFFF, 16'd6}, {16'd2, 16'd9}, 0, 2'd3, 0, 0);
    run_op("R5 frac doubling", 0, {16'h4000, 16'hC000}, {16'h2000, 16'h4000}, 0, 2'd0, 1, 0);
    run_op("R6 frac corner", 1, {16'h8000, 16'h0001}, {16'h8000, 16'h0001}, 0, 2'd0, 1, 0);
    run_op("R8 no corner without frac", 2, 32'h80008000, 32'h80008000, 0, 2'd0, 0, 0);
    run_op("R8 grow past 32 bits", 2, 32'h80008000, 32'h80008000, 0, 2'd0, 0, 0);
    run_op("R7 clamp high", 2, 32'h00010001, 32'h00010001, 0, 2'd0, 0, 1);
    run_op("R8 go negative", 3, 32'h7FFF7FFF, 32'h7FFF7FFF, 0, 2'd1, 0, 0);
    for (int k = 0; k < 4; k++)
      run_op("R8 wrap deep negative", 3, 32'h80008000, 32'h80008000, 0, 2'd1, 1, 0);
    run_op("R7 clamp low", 3, 32'h00010001, 32'h00010001, 0, 2'd0, 0, 1);
    @(negedge clk);
    check64("R9 done drops", 64'(done), 64'd0);
    opa = 32'h12345678; opb = 32'h7FFF7FFF; acc_sel = 2'd0; sat_en = 1'b1;
    @(negedge clk);
    check_all("R12 no start no change");
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if ($urandom_range(3) == 0) a[15:0] = 16'h8000;
      if ($urandom_range(3) == 0) b[31:16] = 16'h8000;
      if ($urandom_range(3) == 0) b[15:0] = 16'h8000;
      if ($urandom_range(3) == 0) a[31:16] = 16'h8000;
      run_op("R1-mix random", int'($urandom_range(3)), a, b, 1'($urandom),
             2'($urandom), 1'($urandom), ($urandom_range(4) == 0));
      if (n == 200) do_reset();
    end
    do_reset();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule